// File: doc/BRIEF.md
# Radio Coexistence Medium Arbiter

This block decides when a short-range radio baseband may use the shared 2.4 GHz band while a WLAN transceiver sits next to it on the same board. The baseband scheduler raises a transmit or receive request, with a high-priority flag for slots that must not be lost (voice, for example). The block answers with a grant. It also drives or samples four general-purpose pins that carry the coexistence handshake with the WLAN device.

Five arbitration schemes share the same four pins, and each scheme gives the pins a different meaning. A mode code selects the scheme, together with a host bit that chooses the lead side in the two-wire scheme. Both are taken into the block only while the scheduler has no request open, so a slot in progress never sees its pin meaning change. Pin 1 is the only pin that is ever an input, and it passes through a multi-flop synchronizer before any decision uses it. Pins are numbered 1 to 4, and pin n is bit n-1 of the pin buses.

Top module: `medshare_arb`

## Requirements
- R1: After reset the active scheme is packet arbitration (code 0), whatever the mode code input holds, so that pin_oe reads 4'b0110 while reset is asserted.
- R2: A new mode code or lead-side bit is taken in on a clock edge only when neither bb_tx_req nor bb_rx_req is high. While a request stays high, the old scheme remains in force.
- R3: Mode codes 5, 6 and 7 are ignored. The previously active scheme stays in force.
- R4: Packet arbitration (code 0): pin 2 is a driven output that is high while any request is open, and pin 3 is a driven output status that is high while a request is open with bb_hi_prio set. Pins 1 and 4 are not driven. A request is granted when the synchronized pin 1 (transmit confirm from the WLAN) is high.
- R5: In packet arbitration, a request with bb_hi_prio set is granted even when the confirm on pin 1 is low.
- R6: WLAN-lead inhibit (code 1): no pin is driven. A request is granted only while the synchronized pin 1 (WLAN not-allowed line) is low. Priority has no effect.
- R7: Radio-lead inhibit (code 2): pin 2 is a driven output that is high whenever a request is open, and every request is granted.
- R8: Two-wire (code 3): pin 2 is driven. With the lead bit set, pin 2 is held low and grants follow R6 using pin 1. With the lead bit clear, pin 2 and the grant follow R7.
- R9: Alternating access (code 4): no pin is driven. A request is granted only while the synchronized pin 1 (medium-free) is high. Priority has no effect.
- R10: A change on pin 1 first affects the grant after the second rising clock edge that follows it. After one edge the grant still reflects the old pin level.
- R11: With coex_en low, every request is granted, and all pin outputs and output enables are low.
- R12: bb_grant is never high unless bb_tx_req or bb_rx_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coex_en | input | 1 | Enables the pin handshake; when low, requests are granted freely |
| mode_code | input | 3 | Requested arbitration scheme, codes 0 to 4 |
| host_wlan_lead | input | 1 | Two-wire scheme: 1 makes the WLAN the lead side |
| bb_tx_req | input | 1 | Baseband transmit request |
| bb_rx_req | input | 1 | Baseband receive request |
| bb_hi_prio | input | 1 | The open request is high priority |
| bb_grant | output | 1 | Baseband may use the air |
| cx_in_p1 | input | 1 | Level sampled on coexistence pin 1 |
| cx_pin_out | output | 4 | Values driven on pins 4..1 |
| cx_pin_oe | output | 4 | Output enables for pins 4..1 |

## Verification
Request inputs and coex_en reach the grant and the pin buses through logic alone, so the bench checks those outputs one time unit after it changes them, in the same cycle. A new mode code takes effect on the first rising edge at which no request is open, and a pin 1 level takes effect on the second rising edge. Each table entry therefore sets up the scheme and pin level with requests low, waits three falling edges, and only then raises the requests and checks. The directed tests sample at the falling edge after one rising edge and after two rising edges, which separates synchronizer latency from mode latching.

// File: rtl/medshare_pkg.sv
package medshare_pkg;

   typedef enum logic [2:0] {
      MS_ARB         = 3'd0,
      MS_WLAN_LEAD   = 3'd1,
      MS_RADIO_LEAD  = 3'd2,
      MS_DUAL        = 3'd3,
      MS_ALT         = 3'd4
   } ms_mode_e;

   localparam int unsigned MS_PINS = 4;

   // pin n lives at bit n-1
   localparam int unsigned MS_P1 = 0;
   localparam int unsigned MS_P2 = 1;
   localparam int unsigned MS_P3 = 2;

   function automatic logic ms_code_ok(input logic [2:0] code);
      return code <= 3'd4;
   endfunction

endpackage

// File: rtl/medshare_sync.sv
module medshare_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_stage_chk
      $error("medshare_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/medshare_cfg.sv
module medshare_cfg
   import medshare_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic [2:0] mode_code,
   input  logic     host_wlan_lead,
   input  logic     busy,
   output ms_mode_e mode_q,
   output logic     wlan_lead_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= MS_ARB;
         wlan_lead_q <= 1'b0;
      end else if (!busy) begin
         if (ms_code_ok(mode_code)) mode_q <= ms_mode_e'(mode_code);
         wlan_lead_q <= host_wlan_lead;
      end
   end

   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(mode_q) && $stable(wlan_lead_q)));

   // R3
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ms_code_ok(mode_code) |=> $stable(mode_q));

endmodule

// File: rtl/medshare_decide.sv
module medshare_decide
   import medshare_pkg::*;
#(
   parameter bit PRIO_OVERRIDE = 1'b1
) (
   input  logic         en,
   input  ms_mode_e     mode,
   input  logic         wlan_lead,
   input  logic         tx_req,
   input  logic         rx_req,
   input  logic         hi_prio,
   input  logic         p1_s,
   output logic         grant,
   output logic [MS_PINS-1:0] pout,
   output logic [MS_PINS-1:0] poe
);

   logic req;
   logic prio_win;

   assign req = tx_req | rx_req;

   if (PRIO_OVERRIDE) begin : g_prio
      assign prio_win = hi_prio;
   end else begin : g_noprio
      assign prio_win = 1'b0;
   end

   always_comb begin
      grant = 1'b0;
      pout  = '0;
      poe   = '0;
      if (!en) begin
         grant = req;
      end else begin
         case (mode)
            MS_ARB: begin
               poe[MS_P2]  = 1'b1;
               poe[MS_P3]  = 1'b1;
               pout[MS_P2] = req;
               pout[MS_P3] = req & hi_prio;
               grant       = req & (prio_win | p1_s);
            end
            MS_WLAN_LEAD: begin
               grant = req & ~p1_s;
            end
            MS_RADIO_LEAD: begin
               poe[MS_P2]  = 1'b1;
               pout[MS_P2] = req;
               grant       = req;
            end
            MS_DUAL: begin
               poe[MS_P2] = 1'b1;
               if (wlan_lead) begin
                  grant = req & ~p1_s;
               end else begin
                  pout[MS_P2] = req;
                  grant       = req;
               end
            end
            MS_ALT: begin
               grant = req & p1_s;
            end
            default: begin
               grant = 1'b0;
            end
         endcase
      end
   end

   // R12
   always_comb begin
      grant_req_imm_chk: assert (!(grant && !req) || $isunknown(grant));
   end

endmodule

// File: rtl/medshare_arb.sv
module medshare_arb
   import medshare_pkg::*;
#(
   parameter int unsigned PIN_COUNT     = 4,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          PRIO_OVERRIDE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 coex_en,
   input  logic [2:0]           mode_code,
   input  logic                 host_wlan_lead,
   input  logic                 bb_tx_req,
   input  logic                 bb_rx_req,
   input  logic                 bb_hi_prio,
   output logic                 bb_grant,
   input  logic                 cx_in_p1,
   output logic [PIN_COUNT-1:0] cx_pin_out,
   output logic [PIN_COUNT-1:0] cx_pin_oe
);

   if (PIN_COUNT != MS_PINS) begin : g_pin_chk
      $error("medshare_arb: PIN_COUNT must equal the four coexistence pins");
   end

   localparam int unsigned P1_W = 1;

   logic     busy;
   logic     p1_s;
   ms_mode_e mode_q;
   logic     wlan_lead_q;

   assign busy = bb_tx_req | bb_rx_req;

   medshare_sync #(.W(P1_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cx_in_p1),
      .q     (p1_s)
   );

   medshare_cfg i_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_code      (mode_code),
      .host_wlan_lead (host_wlan_lead),
      .busy           (busy),
      .mode_q         (mode_q),
      .wlan_lead_q    (wlan_lead_q)
   );

   medshare_decide #(.PRIO_OVERRIDE(PRIO_OVERRIDE)) i_decide (
      .en        (coex_en),
      .mode      (mode_q),
      .wlan_lead (wlan_lead_q),
      .tx_req    (bb_tx_req),
      .rx_req    (bb_rx_req),
      .hi_prio   (bb_hi_prio),
      .p1_s      (p1_s),
      .grant     (bb_grant),
      .pout      (cx_pin_out),
      .poe       (cx_pin_oe)
   );

   // R12
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bb_grant |-> busy);

   // R6
   wlan_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coex_en && mode_q == MS_WLAN_LEAD && p1_s) |-> !bb_grant);

   // R7
   radio_na_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coex_en && mode_q == MS_RADIO_LEAD && busy) |->
         (cx_pin_out[MS_P2] && cx_pin_oe[MS_P2] && bb_grant));

   // R8
   dual_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coex_en && mode_q == MS_DUAL && wlan_lead_q && p1_s) |-> !bb_grant);

   // R9
   alt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coex_en && mode_q == MS_ALT && !p1_s) |-> !bb_grant);

   // R11
   dis_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !coex_en |-> (cx_pin_oe == '0 && cx_pin_out == '0));

endmodule

// File: tb/test_medshare_arb.sv
`timescale 1ns/1ps
module test_medshare_arb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       coex_en;
   logic [2:0] mode_code;
   logic       host_wlan_lead;
   logic       bb_tx_req, bb_rx_req, bb_hi_prio;
   logic       bb_grant;
   logic       cx_in_p1;
   logic [3:0] cx_pin_out, cx_pin_oe;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   medshare_arb i_medshare_arb (
      .clk            (clk),
      .rst_n          (rst_n),
      .coex_en        (coex_en),
      .mode_code      (mode_code),
      .host_wlan_lead (host_wlan_lead),
      .bb_tx_req      (bb_tx_req),
      .bb_rx_req      (bb_rx_req),
      .bb_hi_prio     (bb_hi_prio),
      .bb_grant       (bb_grant),
      .cx_in_p1       (cx_in_p1),
      .cx_pin_out     (cx_pin_out),
      .cx_pin_oe      (cx_pin_oe)
   );

   // {mode, lead, tx, rx, hi, p1, exp_grant, exp_out, exp_oe}
   localparam int NV = 15;
   localparam logic [16:0] VEC [NV] = '{
      17'b000_0_1_0_0_1_1_0010_0110,
      17'b000_0_0_1_0_0_0_0010_0110,
      17'b000_0_1_0_1_0_1_0110_0110,
      17'b000_0_0_0_0_1_0_0000_0110,
      17'b001_0_1_0_0_1_0_0000_0000,
      17'b001_0_1_0_1_0_1_0000_0000,
      17'b001_0_0_1_0_0_1_0000_0000,
      17'b010_0_1_0_0_1_1_0010_0010,
      17'b010_0_0_0_0_0_0_0000_0010,
      17'b011_1_1_0_0_1_0_0000_0010,
      17'b011_1_0_1_0_0_1_0000_0010,
      17'b011_0_1_0_0_1_1_0010_0010,
      17'b100_0_1_0_0_0_0_0000_0000,
      17'b100_0_0_1_0_1_1_0000_0000,
      17'b100_0_1_0_1_0_0_0000_0000
   };

   function automatic string tag_of(input logic [2:0] m);
      case (m)
         3'd0:    return "R4 R5";
         3'd1:    return "R6";
         3'd2:    return "R7";
         3'd3:    return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; coex_en = 1'b1; mode_code = 3'd2; host_wlan_lead = 1'b0;
      bb_tx_req = 1'b1; bb_rx_req = 1'b0; bb_hi_prio = 1'b0; cx_in_p1 = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R1: arbitration scheme during reset despite code 2
      chk("R1 oe",    cx_pin_oe,        4'b0110);
      chk("R1 out",   cx_pin_out,       4'b0010);
      chk("R1 grant", {3'b0, bb_grant}, 4'b0000);
      bb_tx_req = 1'b0; mode_code = 3'd0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         bb_tx_req = 1'b0; bb_rx_req = 1'b0; bb_hi_prio = 1'b0;
         mode_code      = VEC[v][16:14];
         host_wlan_lead = VEC[v][13];
         cx_in_p1       = VEC[v][9];
         repeat (3) @(negedge clk);
         bb_tx_req  = VEC[v][12];
         bb_rx_req  = VEC[v][11];
         bb_hi_prio = VEC[v][10];
         #1;
         chk({tag_of(VEC[v][16:14]), " grant"}, {3'b0, bb_grant}, {3'b0, VEC[v][8]});
         chk({tag_of(VEC[v][16:14]), " out"},   cx_pin_out, VEC[v][7:4]);
         chk({tag_of(VEC[v][16:14]), " oe"},    cx_pin_oe,  VEC[v][3:0]);
         // R12: no request, no grant
         if (!VEC[v][12] && !VEC[v][11]) chk("R12", {3'b0, bb_grant}, 4'b0000);
         @(negedge clk);
      end

      // R2: mode change deferred while a request is open
      bb_tx_req = 1'b0; bb_rx_req = 1'b0; bb_hi_prio = 1'b0;
      mode_code = 3'd0; cx_in_p1 = 1'b0;
      repeat (3) @(negedge clk);
      bb_tx_req = 1'b1;
      @(negedge clk);
      mode_code = 3'd1;
      repeat (3) @(negedge clk);
      #1;
      chk("R2 held oe", cx_pin_oe, 4'b0110);
      @(negedge clk);
      bb_tx_req = 1'b0;
      @(negedge clk);
      #1;
      chk("R2 taken oe", cx_pin_oe, 4'b0000);

      // R3: unused code ignored
      mode_code = 3'd2;
      repeat (2) @(negedge clk);
      mode_code = 3'd5;
      repeat (3) @(negedge clk);
      bb_tx_req = 1'b1;
      #1;
      chk("R3 oe",    cx_pin_oe,        4'b0010);
      chk("R3 grant", {3'b0, bb_grant}, 4'b0001);
      @(negedge clk);

      // R10: two-edge synchronizer latency on pin 1
      bb_tx_req = 1'b0;
      mode_code = 3'd1; cx_in_p1 = 1'b0;
      repeat (3) @(negedge clk);
      bb_tx_req = 1'b1;
      #1;
      chk("R10 start", {3'b0, bb_grant}, 4'b0001);
      @(negedge clk);
      cx_in_p1 = 1'b1;
      @(negedge clk);
      #1;
      chk("R10 one edge", {3'b0, bb_grant}, 4'b0001);
      @(negedge clk);
      #1;
      chk("R10 two edges", {3'b0, bb_grant}, 4'b0000);

      // R11: disabled gives free access, pins released
      @(negedge clk);
      coex_en = 1'b0;
      #1;
      chk("R11 grant", {3'b0, bb_grant}, 4'b0001);
      chk("R11 oe",    cx_pin_oe,        4'b0000);
      chk("R11 out",   cx_pin_out,       4'b0000);
      @(negedge clk);
      coex_en = 1'b1;
      #1;
      chk("R6 re-enabled", {3'b0, bb_grant}, 4'b0000);

      finish_run();
   end

endmodule